// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Register Block

This block holds the interrupt pending word for one processor. Software reaches it through a small word-addressed port. Through that port it reads the pending word, sets soft interrupt bits and clears them. Hardware sources can also force individual low-order level bits in the same word, one bit per update. Typical sources are the processor's local timer and device levels steered to this processor.

The upper part of the pending word forms the soft interrupt levels. Bits 31 down to 17 are moved down by sixteen positions onto levels 15 down to 1. The resulting 16-bit vector leaves the block straight from the pending flop, and the system controller merges it into the processor's priority-level lines. The clear register has one special case: a 1 in bit 14 of a clear value also clears bit 31, which is the soft level-15 bit.

Several hardware update ports can be built in, set by a parameter. A software write and hardware updates can land in the same cycle, and they are applied in a fixed order.

Top module: `swint_cpu_regs`

## Requirements
- R1: After reset the pending word is zero, the soft level vector is zero and the read data is zero.
- R2: A read (valid high, write low) of word address 0 returns the pending word as it stood at that clock edge. The read data and read-valid appear one cycle after the request.
- R3: A read of any word address other than 0 returns zero.
- R4: A write to word address 2 ORs the written value, masked to bits 31..17, into the pending word. Bits 16..0 of the value have no effect.
- R5: A write to word address 1 clears from the pending word the bits of the value that lie in 31..17. Pending bits 16..0 are left unchanged.
- R6: In a write to word address 1, a 1 in bit 14 of the value also clears pending bit 31. Pending bit 14 itself is not cleared.
- R7: Writes to word addresses 0 and 3 and above leave the pending word unchanged.
- R8: Soft level output bit n (n = 1..15) equals pending bit n+16. Output bit 0 is always 0. The output follows the pending word in the same cycle the flop updates.
- R9: A hardware port pulse with valid high sets pending bit L (L = the port's 4-bit level field) when its set flag is 1, and clears that bit when the flag is 0.
- R10: Updates that land in the same cycle are applied in this order: the software write first, then hardware ports from index 0 upward. The highest-numbered port that touches a bit decides that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write value |
| bus_rdata_o | output | DATA_W | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| hw_valid_i | input | N_HW | Per-port update strobe |
| hw_set_i | input | N_HW | Per-port 1 = set bit, 0 = clear bit |
| hw_level_i | input | N_HW*LVL_W | Per-port level bit index, packed |
| soft_lvl_o | output | N_LVL | Soft interrupt level vector |

## Verification
The bench uses the default parameters. These are a 32-bit word, a 4-bit word address, two hardware ports with 4-bit level fields, and a 16-level output. A 4-bit address covers word 3 and higher unused words as well as the three decoded ones. Two ports allow two hardware updates to the same bit in one cycle, which exercises the ordering rule. The 4-bit level field reaches bit 14, so the bench can show that the clear alias drops bit 31 but leaves a hardware-set bit 14 in place.

// File: rtl/swint_pkg.sv
package swint_pkg;
  // Word addresses whose meaning the decoder depends on
  localparam int unsigned WORD_PEND = 0;
  localparam int unsigned WORD_CLR  = 1;
  localparam int unsigned WORD_SET  = 2;

  typedef enum logic [1:0] {
    SW_NONE = 2'd0,
    SW_SET  = 2'd1,
    SW_CLR  = 2'd2
  } sw_op_e;
endpackage

// File: rtl/swint_decode.sv
module swint_decode
  import swint_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SOFT_LSB  = 17,
  parameter int unsigned ALIAS_SRC = 14,
  parameter int unsigned ALIAS_DST = 31
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sw_op_e            op_o,
  output logic [DATA_W-1:0] bits_o,
  output logic              rd_req_o,
  output logic              rd_hit_o
);
  localparam logic [DATA_W-1:0] SOFT_MASK = {DATA_W{1'b1}} << SOFT_LSB;
  localparam logic [DATA_W-1:0] ALIAS_BIT = {{(DATA_W-1){1'b0}}, 1'b1} << ALIAS_DST;

  logic [DATA_W-1:0] clr_raw;

  always_comb begin
    clr_raw = wdata_i | (wdata_i[ALIAS_SRC] ? ALIAS_BIT : '0);
    op_o    = SW_NONE;
    bits_o  = '0;
    if (valid_i && write_i) begin
      if (addr_i == ADDR_W'(WORD_SET)) begin
        op_o   = SW_SET;
        bits_o = wdata_i & SOFT_MASK;
      end else if (addr_i == ADDR_W'(WORD_CLR)) begin
        op_o   = SW_CLR;
        bits_o = clr_raw & SOFT_MASK;
      end
    end
  end

  assign rd_req_o = valid_i && !write_i;
  assign rd_hit_o = (addr_i == ADDR_W'(WORD_PEND));
endmodule

// File: rtl/swint_pending.sv
module swint_pending
  import swint_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_HW   = 2,
  parameter int unsigned LVL_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  sw_op_e                op_i,
  input  logic [DATA_W-1:0]     bits_i,
  input  logic [N_HW-1:0]       hw_valid_i,
  input  logic [N_HW-1:0]       hw_set_i,
  input  logic [N_HW*LVL_W-1:0] hw_level_i,
  output logic [DATA_W-1:0]     pend_o
);
  logic [DATA_W-1:0] pend_q, after_sw;
  logic [DATA_W-1:0] stage [N_HW+1];

  always_comb begin
    unique case (op_i)
      SW_SET:  after_sw = pend_q | bits_i;
      SW_CLR:  after_sw = pend_q & ~bits_i;
      default: after_sw = pend_q;
    endcase
  end

  assign stage[0] = after_sw;

  // One update stage per hardware port; a later port overrides an earlier one
  for (genvar g = 0; g < N_HW; g++) begin : g_hw
    logic [LVL_W-1:0] idx;
    assign idx = hw_level_i[g*LVL_W +: LVL_W];
    always_comb begin
      stage[g+1] = stage[g];
      if (hw_valid_i[g]) stage[g+1][idx] = hw_set_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= stage[N_HW];
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/swint_rdport.sv
module swint_rdport #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_i,
  input  logic              rd_hit_i,
  input  logic [DATA_W-1:0] pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_req_i;
      if (rd_req_i) rdata_o <= rd_hit_i ? pend_i : '0;
    end
  end
endmodule

// File: rtl/swint_lvlmap.sv
module swint_lvlmap #(
  parameter int unsigned N_LVL     = 16,
  parameter int unsigned LVL_SHIFT = 16,
  parameter int unsigned SOFT_LSB  = 17
) (
  input  logic [N_LVL-1:0] upper_i,
  output logic [N_LVL-1:0] lvl_o
);
  localparam int unsigned LOW_ZERO = SOFT_LSB - LVL_SHIFT;
  localparam logic [N_LVL-1:0] KEEP = {N_LVL{1'b1}} << LOW_ZERO;

  assign lvl_o = upper_i & KEEP;
endmodule

// File: rtl/swint_cpu_regs.sv
module swint_cpu_regs
  import swint_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned N_HW      = 2,
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned N_LVL     = 16,
  parameter int unsigned SOFT_LSB  = 17,
  parameter int unsigned ALIAS_SRC = 14,
  parameter int unsigned ALIAS_DST = 31
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  bus_rvalid_o,
  input  logic [N_HW-1:0]       hw_valid_i,
  input  logic [N_HW-1:0]       hw_set_i,
  input  logic [N_HW*LVL_W-1:0] hw_level_i,
  output logic [N_LVL-1:0]      soft_lvl_o
);
  localparam int unsigned LVL_SHIFT = DATA_W - N_LVL;

  sw_op_e            sw_op;
  logic [DATA_W-1:0] sw_bits;
  logic              rd_req, rd_hit;
  logic [DATA_W-1:0] pend_q;

  swint_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SOFT_LSB(SOFT_LSB),
    .ALIAS_SRC(ALIAS_SRC), .ALIAS_DST(ALIAS_DST)
  ) u_dec (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .op_o(sw_op), .bits_o(sw_bits),
    .rd_req_o(rd_req), .rd_hit_o(rd_hit)
  );

  swint_pending #(.DATA_W(DATA_W), .N_HW(N_HW), .LVL_W(LVL_W)) u_pend (
    .clk(clk), .rst(rst), .op_i(sw_op), .bits_i(sw_bits),
    .hw_valid_i(hw_valid_i), .hw_set_i(hw_set_i), .hw_level_i(hw_level_i),
    .pend_o(pend_q)
  );

  swint_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_req_i(rd_req), .rd_hit_i(rd_hit),
    .pend_i(pend_q), .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  swint_lvlmap #(.N_LVL(N_LVL), .LVL_SHIFT(LVL_SHIFT), .SOFT_LSB(SOFT_LSB)) u_map (
    .upper_i(pend_q[LVL_SHIFT +: N_LVL]), .lvl_o(soft_lvl_o)
  );
endmodule

// File: rtl/swint_cpu_regs_chk.sv
module swint_cpu_regs_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned N_HW      = 2,
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned N_LVL     = 16,
  parameter int unsigned SOFT_LSB  = 17,
  parameter int unsigned ALIAS_SRC = 14,
  parameter int unsigned ALIAS_DST = 31
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_valid_i,
  input logic                  bus_write_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic [DATA_W-1:0]     bus_wdata_i,
  input logic [DATA_W-1:0]     bus_rdata_o,
  input logic                  bus_rvalid_o,
  input logic [N_HW-1:0]       hw_valid_i,
  input logic [N_HW-1:0]       hw_set_i,
  input logic [N_HW*LVL_W-1:0] hw_level_i,
  input logic [N_LVL-1:0]      soft_lvl_o,
  input logic [DATA_W-1:0]     pend_q
);
  localparam logic [DATA_W-1:0] SOFT_MASK = {DATA_W{1'b1}} << SOFT_LSB;

  logic prev_rst_q;
  always_ff @(posedge clk) prev_rst_q <= rst;

  // R1: first edge after reset sees cleared state
  always_ff @(posedge clk) begin
    if (prev_rst_q === 1'b1 && rst === 1'b0)
      p_reset_state_r1: assert (pend_q == '0 && soft_lvl_o == '0 && bus_rdata_o == '0);
  end

  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

  p_no_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o);

  p_other_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && !bus_write_i && bus_addr_i != '0) |=> bus_rdata_o == '0);

  p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(2)) |=>
      ((pend_q & $past(bus_wdata_i & SOFT_MASK)) == $past(bus_wdata_i & SOFT_MASK)));

  p_alias_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(1) && bus_wdata_i[ALIAS_SRC])
      |=> !pend_q[ALIAS_DST]);

  p_lvl0_low_r8: assert property (@(posedge clk) disable iff (rst)
    !soft_lvl_o[0]);

  p_lvl_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid_i && bus_write_i) |=> $stable(soft_lvl_o));

  // R9/R10: a port not overridden by a later port decides its bit
  for (genvar g = 0; g < N_HW; g++) begin : g_port
    logic later_busy;
    always_comb begin
      later_busy = 1'b0;
      for (int k = g + 1; k < N_HW; k++) later_busy = later_busy | hw_valid_i[k];
    end
    p_hw_update_r9: assert property (@(posedge clk) disable iff (rst)
      (hw_valid_i[g] && !later_busy) |=>
        pend_q[$past(hw_level_i[g*LVL_W +: LVL_W])] == $past(hw_set_i[g]));
  end
endmodule

bind swint_cpu_regs swint_cpu_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_HW(N_HW), .LVL_W(LVL_W), .N_LVL(N_LVL),
  .SOFT_LSB(SOFT_LSB), .ALIAS_SRC(ALIAS_SRC), .ALIAS_DST(ALIAS_DST)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .bus_rvalid_o(bus_rvalid_o), .hw_valid_i(hw_valid_i), .hw_set_i(hw_set_i),
  .hw_level_i(hw_level_i), .soft_lvl_o(soft_lvl_o), .pend_q(pend_q)
);

// File: tb/swint_cpu_regs_tb.sv
module swint_cpu_regs_tb_top;
  localparam int DW = 32, AW = 4, NH = 2, LW = 4, NL = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_rvalid;
  logic [NH-1:0] hw_valid = '0, hw_set = '0;
  logic [NH*LW-1:0] hw_level = '0;
  logic [NL-1:0] soft_lvl;

  int n_checks = 0, n_fail = 0;
  logic [DW-1:0] model = '0;
  bit done = 0;

  always #5 clk = ~clk;

  swint_cpu_regs dut_i (
    .clk(clk), .rst(rst), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .hw_valid_i(hw_valid), .hw_set_i(hw_set),
    .hw_level_i(hw_level), .soft_lvl_o(soft_lvl)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] lvl_of(logic [DW-1:0] p);
    return {p[31:17], 1'b0};
  endfunction

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic do_read(logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata; v = bus_rvalid;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic hw_pulse(int port, logic s, logic [LW-1:0] l);
    @(negedge clk);
    hw_valid[port] = 1; hw_set[port] = s; hw_level[port*LW +: LW] = l;
    @(negedge clk);
    hw_valid = '0;
  endtask

  task automatic check_state(string req);
    logic [DW-1:0] d; logic v;
    do_read(0, d, v);
    check({req, " pending"}, d, model);
    check({req, " level"}, {16'h0, soft_lvl}, {16'h0, lvl_of(model)});
  endtask

  task automatic t_reset;
    logic [DW-1:0] d; logic v;
    check("R1 rdata after reset", bus_rdata, '0);
    check("R1 level after reset", {16'h0, soft_lvl}, '0);
    do_read(0, d, v);
    check("R1 pending after reset", d, '0);
    check("R2 rvalid on read", {31'h0, v}, 32'h1);
  endtask

  task automatic t_set;
    do_write(2, 32'hFFFF_FFFF);
    model |= 32'hFFFE_0000;
    check("R8 level same cycle as write", {16'h0, soft_lvl}, 32'h0000_FFFE);
    check_state("R4 set masks low bits");
  endtask

  task automatic t_clear;
    do_write(1, 32'h0002_0000 | 32'h0000_00FF);
    model &= ~32'h0002_0000;
    check_state("R5 clear bit17 only");
  endtask

  task automatic t_hw;
    hw_pulse(0, 1, 14); model[14] = 1;
    hw_pulse(1, 1, 3);  model[3] = 1;
    check_state("R9 hw set");
    hw_pulse(0, 0, 3);  model[3] = 0;
    check_state("R9 hw clear");
  endtask

  task automatic t_alias;
    do_write(1, 32'h0000_4000);
    model[31] = 0;
    check_state("R6 alias clears bit31 keeps bit14");
    do_write(1, 32'h0000_FFFF);
    model &= ~32'h8000_0000;
    check_state("R5 low pending bits untouched");
  endtask

  task automatic t_other_reads;
    logic [DW-1:0] d; logic v;
    for (int a = 1; a < 5; a++) begin
      do_read(AW'(a), d, v);
      check($sformatf("R3 read word %0d", a), d, '0);
    end
  endtask

  task automatic t_ignored;
    do_write(0, 32'h0000_0000);
    do_write(3, 32'hFFFF_FFFF);
    do_write(7, 32'h0000_0000);
    check_state("R7 unlisted writes ignored");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 2; bus_wdata = 32'h8000_0000;
    hw_valid = 2'b11; hw_set = 2'b01;
    hw_level = {4'd5, 4'd5};
    @(negedge clk);
    bus_valid = 0; bus_write = 0; hw_valid = '0;
    model[31] = 1; model[5] = 0;
    check_state("R10 sw and hw same cycle, port1 wins");
    @(negedge clk);
    hw_valid = 2'b11; hw_set = 2'b10; hw_level = {4'd6, 4'd6};
    @(negedge clk);
    hw_valid = '0;
    model[6] = 1;
    check_state("R10 port1 set overrides port0 clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    t_reset();
    t_set();
    t_clear();
    t_hw();
    t_alias();
    t_other_reads();
    t_ignored();
    t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule